// File: doc/BRIEF.md
# Cold and Warm Reset Sequencer

This block turns an active-low external reset pin, a supply-good flag and a low-voltage-lockout flag into the reset and gating signals of an on-chip memory subsystem. It keeps apart the first reset after the supply comes up (cold) and any later reset (warm), and it qualifies each against its own minimum pulse width. Both widths are counted in clock cycles. A pulse shorter than the minimum for the current mode is ignored.

While a cold reset is in progress, a loader steps through a configuration sequence and strobes a register-clear pulse. The logic outputs are declared valid only after that sequence finishes. A warm reset leaves them valid. After a qualified release, a fixed blackout window runs before the access-ready output rises. The flash select and write strobes pass only when access is ready, and the write strobe is also blocked at once whenever the lockout flag is high. A mode output requests read-array mode from the flash whenever the subsystem is not ready. Sticky outputs report whether the power-on sequence has completed and whether the last accepted reset was warm.

Top module: `reset_sequencer`

## Requirements
- R1: During and right after the block's own reset, access_ready, por_done, logic_valid, last_warm, flash_sel and flash_wr are 0 and flash_read_array is 1.
- R2: In the cold state, with supply_ok high, an ext_rst_n low pulse of at least COLD_MIN_CYC cycles is accepted. After the blackout, access_ready goes to 1, por_done to 1 and last_warm to 0.
- R3: In the cold state, an ext_rst_n low pulse shorter than COLD_MIN_CYC cycles is ignored, and access_ready stays 0.
- R4: Once supply_ok is high in the cold state, regs_clear pulses for one cycle and cfg_load_en is high for CFG_WORDS consecutive cycles while cfg_load_idx counts 0, 1, ... CFG_WORDS-1. logic_valid rises only after that.
- R5: When ready, an ext_rst_n low pulse of at least WARM_MIN_CYC cycles is a warm reset. access_ready drops within 3 cycles of the pin going low, logic_valid stays 1, no configuration reload happens, and last_warm becomes 1.
- R6: When ready, an ext_rst_n low pulse shorter than WARM_MIN_CYC cycles is ignored. access_ready comes back within 3 cycles of release without a blackout, and last_warm keeps its value.
- R7: After an accepted release, access_ready stays 0 for at least BLACKOUT_CYC+2 cycles after the pin rises and is 1 by BLACKOUT_CYC+4 cycles.
- R8: flash_read_array is 1 whenever access_ready is 0, and 0 while access_ready is 1.
- R9: flash_wr is 0 in the same cycle that low_volt is 1. It follows host_wr again once low_volt has been 0 for 3 cycles while ready.
- R10: flash_sel and flash_wr follow host_sel and host_wr only while access_ready is 1, and are 0 during power-up reset.
- R11: supply_ok going low at any time returns the block to the cold state within 4 cycles, with access_ready, por_done and logic_valid at 0. A configuration reload follows when the supply returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the sequencer itself |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| supply_ok | input | 1 | Supply is steady, asynchronous |
| low_volt | input | 1 | Supply below the lockout threshold, asynchronous |
| host_sel | input | 1 | Requested flash select |
| host_wr | input | 1 | Requested flash write strobe |
| access_ready | output | 1 | Memory access allowed |
| flash_sel | output | 1 | Gated flash select |
| flash_wr | output | 1 | Gated flash write strobe |
| flash_read_array | output | 1 | Requests flash read-array mode |
| cfg_load_en | output | 1 | Configuration word load strobe |
| cfg_load_idx | output | $clog2(CFG_WORDS) | Index of the word being loaded |
| regs_clear | output | 1 | One-cycle clear of the selected registers |
| logic_valid | output | 1 | Logic outputs valid |
| por_done | output | 1 | Sticky: power-on sequence completed |
| last_warm | output | 1 | Last accepted reset was warm |

## Verification
Reset pulses are driven both one cycle shorter than the minimum and exactly at it, in the cold state and the warm state. This separates the two thresholds and shows that a rejected pulse returns without a blackout. A warm pulse followed by a supply drop tells sticky state kept through warm reset apart from state cleared on power loss, and the second supply rise must trigger a fresh configuration reload. The lockout flag is toggled while writes are requested, to show the write is cut in the same cycle and comes back only after the synchronised flag clears.

// File: rtl/rsq_pkg.sv
// Shared types for the reset sequencer.
// Assumes: nothing; pure type definitions.
package rsq_pkg;

    // Main sequencer states.
    typedef enum logic [1:0] {
        S_COLD      = 2'd0,   // waiting for a qualified power-on pulse
        S_WARM_HOLD = 2'd1,   // pin low after running, measuring width
        S_BLACKOUT  = 2'd2,   // released, access still blocked
        S_READY     = 2'd3    // memory access allowed
    } seq_state_e;

    // Configuration loader states.
    typedef enum logic [1:0] {
        L_IDLE = 2'd0,
        L_RUN  = 2'd1,
        L_DONE = 2'd2
    } ld_state_e;

    // Bit positions inside the synchronised input vector.
    localparam int SB_LV  = 0;
    localparam int SB_SUP = 1;
    localparam int SB_PIN = 2;
    localparam int SB_W   = 3;

endpackage

// File: rtl/rsq_sync.sv
// Multi-bit, multi-stage input synchroniser with per-bit reset values.
// Assumes: each bit is independent; no coherency between bits required.
module rsq_sync #(
    parameter int            WIDTH   = 3,
    parameter int            STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg_q [STAGES];

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/rsq_cfg_loader.sv
// Configuration loader: on start, pulses a register clear and then
// steps an index through CFG_WORDS words, one per cycle.
// Assumes: start_i is level; flush_i aborts and forgets completion.
module rsq_cfg_loader
    import rsq_pkg::*;
#(
    parameter int CFG_WORDS = 16,
    localparam int IDX_W = $clog2(CFG_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             flush_i,
    output logic             load_en_o,
    output logic [IDX_W-1:0] load_idx_o,
    output logic             clr_o,
    output logic             done_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CFG_WORDS - 1);

    ld_state_e        st_q;
    logic [IDX_W-1:0] idx_q;
    logic             clr_q;

    // Loader state, index and clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= L_IDLE;
            idx_q <= '0;
            clr_q <= 1'b0;
        end else if (flush_i) begin
            st_q  <= L_IDLE;
            idx_q <= '0;
            clr_q <= 1'b0;
        end else begin
            clr_q <= 1'b0;
            case (st_q)
                L_IDLE: if (start_i) begin
                    st_q  <= L_RUN;
                    idx_q <= '0;
                    clr_q <= 1'b1;
                end
                L_RUN: begin
                    if (idx_q == LAST_IDX) st_q <= L_DONE;
                    else                   idx_q <= idx_q + 1'b1;
                end
                default: st_q <= L_DONE;
            endcase
        end
    end

    assign load_en_o  = (st_q == L_RUN);
    assign load_idx_o = idx_q;
    assign clr_o      = clr_q;
    assign done_o     = (st_q == L_DONE);

    // The index never leaves the configured range while loading.
    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_en_o |-> (32'(load_idx_o) < CFG_WORDS));

    // The clear pulse opens the sequence at index zero.
    assert_clear_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> (load_en_o && load_idx_o == '0));

endmodule

// File: rtl/rsq_ctrl.sv
// Reset sequencer control: measures pin-low width, qualifies cold and
// warm pulses against separate minima, runs the blackout window and
// keeps the sticky status flags.
// Assumes: pin_s and sup_s are already synchronised; WARM_MIN_CYC is not
// above COLD_MIN_CYC; a pulse arriving during blackout is not measured.
module rsq_ctrl
    import rsq_pkg::*;
#(
    parameter int COLD_MIN_CYC = 250000,
    parameter int WARM_MIN_CYC = 38,
    parameter int BLACKOUT_CYC = 30,
    localparam int CNT_W = $clog2(COLD_MIN_CYC + 1),
    localparam int BLK_W = $clog2(BLACKOUT_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic sup_s,
    input  logic cfg_done_i,
    output logic cfg_start_o,
    output logic cfg_flush_o,
    output logic ready_o,
    output logic rd_array_o,
    output logic por_done_o,
    output logic last_warm_o
);

    localparam logic [CNT_W-1:0] COLD_LIM = CNT_W'(COLD_MIN_CYC);
    localparam logic [CNT_W-1:0] WARM_LIM = CNT_W'(WARM_MIN_CYC);
    localparam logic [BLK_W-1:0] BLK_END  = BLK_W'(BLACKOUT_CYC - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] pcnt_q, pcnt_d, pcnt_inc;
    logic [BLK_W-1:0] bcnt_q, bcnt_d;
    logic             acc_cold, acc_warm;
    logic             por_q, lastw_q, rd_q;

    // Saturating increment of the pin-low width counter.
    always_comb pcnt_inc = (pcnt_q == COLD_LIM) ? pcnt_q : pcnt_q + 1'b1;

    // Next-state logic: pulse qualification and blackout timing.
    always_comb begin
        state_d  = state_q;
        pcnt_d   = pcnt_q;
        bcnt_d   = bcnt_q;
        acc_cold = 1'b0;
        acc_warm = 1'b0;
        if (!sup_s) begin
            state_d = S_COLD;
            pcnt_d  = '0;
            bcnt_d  = '0;
        end else begin
            case (state_q)
                S_COLD: begin
                    if (!pin_s) begin
                        pcnt_d = pcnt_inc;
                    end else begin
                        if (pcnt_q >= COLD_LIM && cfg_done_i) begin
                            state_d  = S_BLACKOUT;
                            bcnt_d   = '0;
                            acc_cold = 1'b1;
                        end
                        pcnt_d = '0;
                    end
                end
                S_WARM_HOLD: begin
                    if (!pin_s) begin
                        pcnt_d = pcnt_inc;
                    end else begin
                        if (pcnt_q >= WARM_LIM) begin
                            state_d  = S_BLACKOUT;
                            bcnt_d   = '0;
                            acc_warm = 1'b1;
                        end else begin
                            state_d = S_READY;
                        end
                        pcnt_d = '0;
                    end
                end
                S_BLACKOUT: begin
                    if (bcnt_q == BLK_END) state_d = S_READY;
                    else                   bcnt_d  = bcnt_q + 1'b1;
                end
                default: begin
                    if (!pin_s) begin
                        state_d = S_WARM_HOLD;
                        pcnt_d  = CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_COLD;
            pcnt_q  <= '0;
            bcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
            bcnt_q  <= bcnt_d;
        end
    end

    // Sticky flags and read-array mode request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_q   <= 1'b0;
            lastw_q <= 1'b0;
            rd_q    <= 1'b1;
        end else begin
            rd_q <= (state_d != S_READY);
            if (acc_cold) lastw_q <= 1'b0;
            if (acc_warm) lastw_q <= 1'b1;
            if (!sup_s)
                por_q <= 1'b0;
            else if (state_q == S_BLACKOUT && state_d == S_READY && !lastw_q)
                por_q <= 1'b1;
        end
    end

    assign ready_o     = (state_q == S_READY);
    assign rd_array_o  = rd_q;
    assign por_done_o  = por_q;
    assign last_warm_o = lastw_q;
    assign cfg_start_o = sup_s && (state_q == S_COLD);
    assign cfg_flush_o = !sup_s;

    // A cold release is taken only once configuration is loaded.
    assert_cfg_before_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BLACKOUT && $past(state_q) == S_COLD) |-> cfg_done_i);

    // Configuration stays valid throughout a warm reset.
    assert_valid_in_warm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WARM_HOLD) |-> cfg_done_i);

    // Ready never comes straight out of the cold state.
    assert_ready_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> ($past(state_q) != S_COLD));

    // The power-on flag is kept while the supply stays good.
    assert_por_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (por_q && sup_s) |=> por_q);

    // Read-array mode is requested whenever access is blocked.
    assert_rd_array_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_o |-> rd_q);

endmodule

// File: rtl/rsq_flash_gate.sv
// Flash strobe gating: select and write pass only when access is ready,
// and write is blocked by the raw or synchronised lockout flag.
// Assumes: lv_raw may be asynchronous; it only ever blocks.
module rsq_flash_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ready_i,
    input  logic lv_raw_i,
    input  logic lv_s_i,
    input  logic host_sel_i,
    input  logic host_wr_i,
    output logic flash_sel_o,
    output logic flash_wr_o
);

    // Combinational gating of the host strobes.
    always_comb begin
        flash_sel_o = host_sel_i && ready_i;
        flash_wr_o  = host_wr_i && ready_i && !lv_raw_i && !lv_s_i;
    end

    // No write strobe while the lockout flag is held.
    assert_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lv_raw_i) && lv_raw_i) |-> !flash_wr_o);

    // No flash access while the sequencer blocks access.
    assert_no_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |-> (!flash_sel_o && !flash_wr_o));

endmodule

// File: rtl/reset_sequencer.sv
// Top of the cold/warm reset sequencer: synchronises the asynchronous
// inputs, runs the control FSM and configuration loader, gates flash
// strobes.
// Assumes: COLD_MIN_CYC >= CFG_WORDS + 4; CFG_WORDS >= 2; BLACKOUT_CYC >= 1.
module reset_sequencer
    import rsq_pkg::*;
#(
    parameter int COLD_MIN_CYC = 250000,
    parameter int WARM_MIN_CYC = 38,
    parameter int BLACKOUT_CYC = 30,
    parameter int CFG_WORDS    = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ext_rst_n,
    input  logic                         supply_ok,
    input  logic                         low_volt,
    input  logic                         host_sel,
    input  logic                         host_wr,
    output logic                         access_ready,
    output logic                         flash_sel,
    output logic                         flash_wr,
    output logic                         flash_read_array,
    output logic                         cfg_load_en,
    output logic [$clog2(CFG_WORDS)-1:0] cfg_load_idx,
    output logic                         regs_clear,
    output logic                         logic_valid,
    output logic                         por_done,
    output logic                         last_warm
);

    localparam logic [SB_W-1:0] SYNC_RST = SB_W'(1 << SB_LV);

    logic [SB_W-1:0] raw_vec, syn_vec;
    logic            cfg_start, cfg_flush, cfg_done;

    // Bundle the asynchronous inputs for synchronisation.
    always_comb begin
        raw_vec          = '0;
        raw_vec[SB_PIN]  = ext_rst_n;
        raw_vec[SB_SUP]  = supply_ok;
        raw_vec[SB_LV]   = low_volt;
    end

    rsq_sync #(
        .WIDTH  (SB_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_vec),
        .q_o  (syn_vec)
    );

    rsq_ctrl #(
        .COLD_MIN_CYC(COLD_MIN_CYC),
        .WARM_MIN_CYC(WARM_MIN_CYC),
        .BLACKOUT_CYC(BLACKOUT_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_s      (syn_vec[SB_PIN]),
        .sup_s      (syn_vec[SB_SUP]),
        .cfg_done_i (cfg_done),
        .cfg_start_o(cfg_start),
        .cfg_flush_o(cfg_flush),
        .ready_o    (access_ready),
        .rd_array_o (flash_read_array),
        .por_done_o (por_done),
        .last_warm_o(last_warm)
    );

    rsq_cfg_loader #(
        .CFG_WORDS(CFG_WORDS)
    ) u_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (cfg_start),
        .flush_i   (cfg_flush),
        .load_en_o (cfg_load_en),
        .load_idx_o(cfg_load_idx),
        .clr_o     (regs_clear),
        .done_o    (cfg_done)
    );

    rsq_flash_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .ready_i    (access_ready),
        .lv_raw_i   (low_volt),
        .lv_s_i     (syn_vec[SB_LV]),
        .host_sel_i (host_sel),
        .host_wr_i  (host_wr),
        .flash_sel_o(flash_sel),
        .flash_wr_o (flash_wr)
    );

    assign logic_valid = cfg_done;

    // Logic outputs are never valid while the supply is reported bad.
    assert_valid_needs_supply_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!syn_vec[SB_SUP]) && !syn_vec[SB_SUP]) |-> !logic_valid);

endmodule

// File: tb/sim_reset_sequencer.sv
module sim_reset_sequencer;

    localparam int COLD = 64;
    localparam int WARM = 8;
    localparam int BLK  = 5;
    localparam int CFGW = 6;
    localparam int IW   = $clog2(CFGW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_rst_n = 1'b0, supply_ok = 1'b0, low_volt = 1'b1;
    logic host_sel = 1'b1, host_wr = 1'b1;
    logic access_ready, flash_sel, flash_wr, flash_read_array;
    logic cfg_load_en, regs_clear, logic_valid, por_done, last_warm;
    logic [IW-1:0] cfg_load_idx;

    int checks = 0;
    int errors = 0;
    int loads = 0, clrs = 0, idx_bad = 0, exp_idx = 0;
    bit valid_watch = 0, valid_drop = 0;

    always #2 clk = ~clk;   // 250 MHz

    reset_sequencer #(
        .COLD_MIN_CYC(COLD), .WARM_MIN_CYC(WARM),
        .BLACKOUT_CYC(BLK), .CFG_WORDS(CFGW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
        .supply_ok(supply_ok), .low_volt(low_volt),
        .host_sel(host_sel), .host_wr(host_wr),
        .access_ready(access_ready), .flash_sel(flash_sel),
        .flash_wr(flash_wr), .flash_read_array(flash_read_array),
        .cfg_load_en(cfg_load_en), .cfg_load_idx(cfg_load_idx),
        .regs_clear(regs_clear), .logic_valid(logic_valid),
        .por_done(por_done), .last_warm(last_warm)
    );

    // Load-sequence monitor, sampled 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (cfg_load_en) begin
            if (32'(cfg_load_idx) != exp_idx) idx_bad++;
            exp_idx++;
            loads++;
        end
        if (regs_clear) clrs++;
        if (valid_watch && !logic_valid) valid_drop = 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic mon_clear();
        loads = 0; clrs = 0; idx_bad = 0; exp_idx = 0; valid_drop = 0;
    endtask

    // R1, R4, R10: power-up with pin held low and host strobes requested.
    task automatic t_power_up();
        cyc(5);
        check("R1 ready", access_ready, 0);
        check("R1 read_array", flash_read_array, 1);
        check("R1 por_done", por_done, 0);
        check("R1 logic_valid", logic_valid, 0);
        check("R1 last_warm", last_warm, 0);
        check("R10 sel in reset", flash_sel, 0);
        check("R10 wr in reset", flash_wr, 0);
        rst_n = 1'b1;
        cyc(2);
        mon_clear();
        supply_ok = 1'b1;
        low_volt  = 1'b0;
        cyc(2);
        check("R4 valid before load", logic_valid, 0);
        cyc(20);
        check("R4 load count", loads, CFGW);
        check("R4 index order", idx_bad, 0);
        check("R4 clear pulses", clrs, 1);
        check("R4 valid after load", logic_valid, 1);
        check("R10 sel power-up", flash_sel, 0);
        check("R10 wr power-up", flash_wr, 0);
    endtask

    // R3: short cold pulses are ignored.
    task automatic t_cold_short();
        ext_rst_n = 1'b1;
        cyc(10);
        check("R3 ready after early release", access_ready, 0);
        ext_rst_n = 1'b0;
        cyc(COLD - 1);
        ext_rst_n = 1'b1;
        cyc(BLK + 8);
        check("R3 ready after short pulse", access_ready, 0);
        check("R3 por_done", por_done, 0);
    endtask

    // R2, R7, R8: a full-length cold pulse.
    task automatic t_cold_full();
        ext_rst_n = 1'b0;
        cyc(COLD);
        ext_rst_n = 1'b1;
        cyc(BLK + 2);
        check("R7 ready in blackout", access_ready, 0);
        check("R8 read_array in blackout", flash_read_array, 1);
        cyc(2);
        check("R2 ready after cold", access_ready, 1);
        check("R8 read_array when ready", flash_read_array, 0);
        check("R2 por_done", por_done, 1);
        check("R2 last_warm", last_warm, 0);
        check("R10 sel when ready", flash_sel, 1);
    endtask

    // R6: a warm pulse one cycle short is ignored.
    task automatic t_warm_short();
        ext_rst_n = 1'b0;
        cyc(4);
        check("R6 ready drops", access_ready, 0);
        cyc(WARM - 1 - 4);
        ext_rst_n = 1'b1;
        cyc(4);
        check("R6 ready without blackout", access_ready, 1);
        check("R6 last_warm unchanged", last_warm, 0);
    endtask

    // R5, R7, R8: a warm pulse of exactly the minimum width.
    task automatic t_warm_full();
        mon_clear();
        valid_watch = 1;
        ext_rst_n = 1'b0;
        cyc(4);
        check("R5 ready drops", access_ready, 0);
        check("R8 read_array in warm", flash_read_array, 1);
        cyc(WARM - 4);
        ext_rst_n = 1'b1;
        cyc(BLK + 2);
        check("R7 warm blackout", access_ready, 0);
        cyc(2);
        check("R5 ready after warm", access_ready, 1);
        check("R5 last_warm", last_warm, 1);
        check("R5 no reload", loads, 0);
        check("R5 valid held", 32'(valid_drop), 0);
        check("R5 por_done kept", por_done, 1);
        valid_watch = 0;
    endtask

    // R9: lockout blocks writes at once and releases after sync.
    task automatic t_lockout();
        #1;
        check("R9 wr passes", flash_wr, 1);
        @(negedge clk);
        low_volt = 1'b1;
        #1;
        check("R9 wr blocked same cycle", flash_wr, 0);
        cyc(4);
        check("R9 wr still blocked", flash_wr, 0);
        low_volt = 1'b0;
        cyc(3);
        #1;
        check("R9 wr restored", flash_wr, 1);
    endtask

    // R11: supply loss returns to cold and forces a reload.
    task automatic t_supply_loss();
        supply_ok = 1'b0;
        cyc(4);
        check("R11 ready", access_ready, 0);
        check("R11 por_done", por_done, 0);
        check("R11 logic_valid", logic_valid, 0);
        check("R8 read_array after loss", flash_read_array, 1);
        mon_clear();
        supply_ok = 1'b1;
        cyc(20);
        check("R11 reload count", loads, CFGW);
        check("R11 reload clears", clrs, 1);
        check("R11 ready before pulse", access_ready, 0);
        t_cold_full();
    endtask

    initial begin
        t_power_up();
        t_cold_short();
        t_cold_full();
        t_warm_short();
        t_warm_full();
        t_lockout();
        t_supply_loss();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule